// File: doc/BRIEF.md
# Triggered Multi-Pulse PWM Generator

This block drives a one-bit pulse-width waveform whose timing is counted in strobe samples. The strobe is not an input: a divider on the system clock raises an internal enable once every `CLK_HZ / STROBE_HZ` clocks. All waveform state advances only on that enable. The number of samples in one period is `STROBE_HZ / PERIOD_HZ`. Each period starts on a trigger and runs for exactly that many samples. If no new trigger arrives, the output then stays low.

Inside a period, a phase accumulator steps by the rate input on every sample and wraps at the samples-per-period count. Each wrap opens a new sub-period, so a rate of N gives N sub-periods and N pulses. Two inputs shape each pulse, both in samples counted from the start of its sub-period: the delay input sets where it begins, and the width input sets how long it stays high. A build-time switch selects the update mode. In one mode the settings are frozen at each trigger. In the other they take effect on the very next sample. A strobe output marks every sample.

Top module: `pwm_multi_pulse`

## Requirements
- R1: While the reset input is at its active level (`RST_HIGH`=0 means active low), both outputs are 0. They stay 0 for two further clocks after release, because the reset is asserted asynchronously and released synchronously.
- R2: `strobe_o` is high for exactly one clock in every `CLK_HZ/STROBE_HZ` clocks. Its first pulse comes `CLK_HZ/STROBE_HZ` clocks after the internal reset releases.
- R3: A trigger pulse of at least one clock is held until the next strobe tick, and that tick starts a period. The sample reported on that start tick is 0. The next `SAMPLES` ticks make up the period, with sample index 0 first.
- R4: During a period, `pwm_o` for a sample is 1 exactly when the position in the current sub-period satisfies delay <= position < delay + width. Position 0 is the first sample of each sub-period.
- R5: The accumulator begins each period at 0 and adds the effective rate on every sample. When the sum reaches or exceeds `SAMPLES`, it subtracts `SAMPLES` and the next sample has position 0. A rate of 0 acts as 1, and a rate above `SAMPLES` acts as `SAMPLES`.
- R6: A width of 0 keeps `pwm_o` at 0 for every sample.
- R7: After `SAMPLES` samples with no new trigger, `pwm_o` stays 0 until a trigger arrives. A trigger during a period restarts it from sample 0.
- R8: With `SYNC_UPDATE`=1, rate, width and delay are captured on the start tick. Changes to them during the period do not alter the output.
- R9: With `SYNC_UPDATE`=0, the rate, width and delay values present at each tick govern that sample.
- R10: `pwm_o` changes only in a clock where `strobe_o` is high. Each sample value is held until the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | asynchronous reset, level set by `RST_HIGH` |
| trig_i | input | 1 | period start request |
| rate_i | input | W=$clog2(SAMPLES) | sub-periods per period |
| width_i | input | W | pulse high time in samples |
| delay_i | input | W | pulse start offset in samples |
| pwm_o | output | 1 | waveform, active high |
| strobe_o | output | 1 | one-clock marker for each sample |

## Verification
A wrong divider count shifts `strobe_o` at the first sample after reset, and the per-clock comparison catches it within one divider interval. A wrong accumulator or position counter distorts the sub-period lengths, which shows as a misplaced edge on `pwm_o` within a few samples of the first wrap. A run flag that stays set, or settings captured at the wrong moment, only show up at the end of the period or at the first mid-period change of inputs. For that reason, the stimulus includes idle stretches after each period and input changes in the middle of a period.

// File: rtl/pwm_mp_pkg.sv
package pwm_mp_pkg;
  // integer ratio, never below one
  function automatic int ratio(input int num, input int den);
    int q;
    q = (den > 0) ? num / den : 1;
    return (q < 1) ? 1 : q;
  endfunction
endpackage

// File: rtl/pwm_mp_strobe.sv
module pwm_mp_strobe #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LASTC = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LASTC);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_mp_cfg.sv
module pwm_mp_cfg #(
  parameter int W    = 5,
  parameter bit SYNC = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] rate_i,
  input  logic [W-1:0] wid_i,
  input  logic [W-1:0] dly_i,
  output logic [W-1:0] rate_o,
  output logic [W-1:0] wid_o,
  output logic [W-1:0] dly_o
);
  logic [W-1:0] rate_q, wid_q, dly_q;
  logic [W-1:0] rate_d, wid_d, dly_d;

  always_comb begin
    rate_d = rate_q;
    wid_d  = wid_q;
    dly_d  = dly_q;
    if (load) begin
      rate_d = rate_i;
      wid_d  = wid_i;
      dly_d  = dly_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      wid_q  <= '0;
      dly_q  <= '0;
    end else begin
      rate_q <= rate_d;
      wid_q  <= wid_d;
      dly_q  <= dly_d;
    end
  end

  generate
    if (SYNC) begin : g_held
      assign rate_o = rate_q;
      assign wid_o  = wid_q;
      assign dly_o  = dly_q;
    end else begin : g_live
      assign rate_o = rate_i;
      assign wid_o  = wid_i;
      assign dly_o  = dly_i;
    end
  endgenerate
endmodule

// File: rtl/pwm_mp_seq.sv
module pwm_mp_seq #(
  parameter int SAMPLES = 20,
  parameter int W       = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         trig,
  input  logic [W-1:0] rate,
  input  logic [W-1:0] wid,
  input  logic [W-1:0] dly,
  output logic         start,
  output logic         run,
  output logic         dat,
  output logic         vld
);
  localparam logic [W:0]   NS   = (W+1)'(SAMPLES);
  localparam logic [W-1:0] LAST = W'(SAMPLES - 1);

  logic [W-1:0] smp_q, acc_q, pos_q, smp_d, acc_d, pos_d;
  logic         run_q, pend_q, dat_q, vld_q;
  logic         run_d, pend_d, dat_d;
  logic [W:0]   reff, sum, lim;
  logic         hit;

  always_comb begin
    if (rate == '0)             reff = (W+1)'(1);
    else if ({1'b0, rate} > NS) reff = NS;
    else                        reff = {1'b0, rate};
    sum = {1'b0, acc_q} + reff;
    lim = {1'b0, dly} + {1'b0, wid};
    hit = ({1'b0, pos_q} >= {1'b0, dly}) && ({1'b0, pos_q} < lim);
  end

  always_comb begin
    start  = tick && (pend_q || trig);
    pend_d = tick ? 1'b0 : (pend_q || trig);
    smp_d  = smp_q;
    acc_d  = acc_q;
    pos_d  = pos_q;
    run_d  = run_q;
    dat_d  = dat_q;
    if (start) begin
      smp_d = '0;
      acc_d = '0;
      pos_d = '0;
      run_d = 1'b1;
      dat_d = 1'b0;
    end else if (tick) begin
      dat_d = run_q && hit;
      if (run_q) begin
        smp_d = smp_q + 1'b1;
        run_d = (smp_q != LAST);
        if (sum >= NS) begin
          acc_d = W'(sum - NS);
          pos_d = '0;
        end else begin
          acc_d = sum[W-1:0];
          pos_d = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      acc_q  <= '0;
      pos_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      dat_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      acc_q  <= acc_d;
      pos_q  <= pos_d;
      run_q  <= run_d;
      pend_q <= pend_d;
      dat_q  <= dat_d;
      vld_q  <= tick;
    end
  end

  assign run = run_q;
  assign dat = dat_q;
  assign vld = vld_q;
endmodule

// File: rtl/pwm_multi_pulse.sv
module pwm_multi_pulse #(
  parameter int CLK_HZ      = 100,
  parameter int STROBE_HZ   = 20,
  parameter int PERIOD_HZ   = 1,
  parameter bit SYNC_UPDATE = 1'b1,
  parameter bit RST_HIGH    = 1'b0,
  localparam int DIV     = pwm_mp_pkg::ratio(CLK_HZ, STROBE_HZ),
  localparam int SAMPLES = pwm_mp_pkg::ratio(STROBE_HZ, PERIOD_HZ),
  localparam int W       = (SAMPLES > 2) ? $clog2(SAMPLES) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trig_i,
  input  logic [W-1:0] rate_i,
  input  logic [W-1:0] width_i,
  input  logic [W-1:0] delay_i,
  output logic         pwm_o,
  output logic         strobe_o
);
  logic arst_n, sync1_q, rst_sync_n;
  logic tick, start, run_w;
  logic [W-1:0] cfg_rate, cfg_wid, cfg_dly;

  assign arst_n = RST_HIGH ? ~rst : rst;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync1_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      sync1_q    <= 1'b1;
      rst_sync_n <= sync1_q;
    end
  end

  pwm_mp_strobe #(.DIV(DIV)) u_strobe (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick)
  );

  pwm_mp_cfg #(.W(W), .SYNC(SYNC_UPDATE)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .load(start),
    .rate_i(rate_i), .wid_i(width_i), .dly_i(delay_i),
    .rate_o(cfg_rate), .wid_o(cfg_wid), .dly_o(cfg_dly)
  );

  pwm_mp_seq #(.SAMPLES(SAMPLES), .W(W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .trig(trig_i),
    .rate(cfg_rate), .wid(cfg_wid), .dly(cfg_dly),
    .start(start), .run(run_w), .dat(pwm_o), .vld(strobe_o)
  );
endmodule

// File: rtl/pwm_multi_pulse_chk.sv
module pwm_multi_pulse_chk #(
  parameter int DIV = 5,
  parameter int W   = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         vld,
  input logic         dat,
  input logic         run,
  input logic [W-1:0] wid
);
  int gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gap_q <= 0;
    else if (vld) gap_q <= 0;
    else          gap_q <= gap_q + 1;
  end

  // R2: strobe never stays away longer than one divider interval
  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= DIV);

  generate
    if (DIV > 1) begin : g_single
      // R2: strobe lasts one clock
      p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);
    end
  endgenerate

  // R10: waveform moves only with the strobe
  p_dat_on_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dat) |-> vld);

  // R7: no period running means a low sample
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !$past(run)) |-> !dat);

  // R6: zero width gives a low sample
  p_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && ($past(wid) == '0)) |-> !dat);
endmodule

bind pwm_multi_pulse pwm_multi_pulse_chk #(.DIV(DIV), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .vld(strobe_o), .dat(pwm_o),
  .run(run_w), .wid(cfg_wid)
);

// File: tb/sim_pwm_multi_pulse.sv
module pwm_ref_model #(
  parameter int DIV     = 5,
  parameter int SAMPLES = 20,
  parameter bit SYNC    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  int   rate,
  input  int   wid,
  input  int   dly,
  output logic e_dat,
  output logic e_vld
);
  int  cnt, smp, acc, pos, c_rate, c_wid, c_dly, r, w, d;
  bit  s1, s2, run, pend, tk, st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; cnt = 0; smp = 0; acc = 0; pos = 0;
      run = 0; pend = 0; c_rate = 0; c_wid = 0; c_dly = 0;
      e_dat = 0; e_vld = 0;
    end else if (!s2) begin
      s2 = s1; s1 = 1;
    end else begin
      tk  = (cnt == DIV - 1);
      cnt = tk ? 0 : cnt + 1;
      st  = tk && (pend || trig);
      pend = tk ? 0 : (pend || trig);
      r = SYNC ? c_rate : rate;
      w = SYNC ? c_wid  : wid;
      d = SYNC ? c_dly  : dly;
      if (r == 0) r = 1;
      if (r > SAMPLES) r = SAMPLES;
      if (st) begin
        c_rate = rate; c_wid = wid; c_dly = dly;
        smp = 0; acc = 0; pos = 0; run = 1; e_dat = 0;
      end else if (tk) begin
        e_dat = run && (pos >= d) && (pos < d + w);
        if (run) begin
          run = (smp != SAMPLES - 1);
          smp = smp + 1;
          acc = acc + r;
          if (acc >= SAMPLES) begin acc = acc - SAMPLES; pos = 0; end
          else pos = pos + 1;
        end
      end
      e_vld = tk;
    end
  end
endmodule

module sim_pwm_multi_pulse;
  localparam int CLK_HZ = 100, STROBE_HZ = 20, PERIOD_HZ = 1;
  localparam int DIV = CLK_HZ / STROBE_HZ;
  localparam int SAMPLES = STROBE_HZ / PERIOD_HZ;
  localparam int W = $clog2(SAMPLES);

  logic clk = 1'b0, rst = 1'b0, trig = 1'b0;
  logic [W-1:0] rate = '0, wid = '0, dly = '0;
  logic d0, v0, d1, v1, e_d0, e_v0, e_d1, e_v1;
  int errors = 0, checks = 0, cycles = 0;
  int hi0, hi1, ri0, ri1;
  bit p0, p1;

  always #4 clk = ~clk;

  pwm_multi_pulse #(.CLK_HZ(CLK_HZ), .STROBE_HZ(STROBE_HZ), .PERIOD_HZ(PERIOD_HZ),
    .SYNC_UPDATE(1'b1)) u0 (.clk(clk), .rst(rst), .trig_i(trig), .rate_i(rate),
    .width_i(wid), .delay_i(dly), .pwm_o(d0), .strobe_o(v0));
  pwm_multi_pulse #(.CLK_HZ(CLK_HZ), .STROBE_HZ(STROBE_HZ), .PERIOD_HZ(PERIOD_HZ),
    .SYNC_UPDATE(1'b0)) u1 (.clk(clk), .rst(rst), .trig_i(trig), .rate_i(rate),
    .width_i(wid), .delay_i(dly), .pwm_o(d1), .strobe_o(v1));

  pwm_ref_model #(.DIV(DIV), .SAMPLES(SAMPLES), .SYNC(1'b1)) m0 (.clk(clk), .rst_n(rst),
    .trig(trig), .rate(int'(rate)), .wid(int'(wid)), .dly(int'(dly)), .e_dat(e_d0), .e_vld(e_v0));
  pwm_ref_model #(.DIV(DIV), .SAMPLES(SAMPLES), .SYNC(1'b0)) m1 (.clk(clk), .rst_n(rst),
    .trig(trig), .rate(int'(rate)), .wid(int'(wid)), .dly(int'(dly)), .e_dat(e_d1), .e_vld(e_v1));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    chk(v0, e_v0, "R2 strobe sync");
    chk(d0, e_d0, "R4 waveform sync");
    chk(v1, e_v1, "R2 strobe live");
    chk(d1, e_d1, "R9 waveform live");
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL R3 watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!v0);
  endtask

  task automatic sample(input int n);
    for (int i = 0; i < n; i++) begin
      wait_tick();
      if (d0) hi0++;
      if (d1) hi1++;
      if (d0 && !p0) ri0++;
      if (d1 && !p1) ri1++;
      p0 = d0; p1 = d1;
    end
  endtask

  task automatic start_period();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    wait_tick();
    hi0 = 0; hi1 = 0; ri0 = 0; ri1 = 0; p0 = 0; p1 = 0;
    chk(d0, 0, "R3 start sample low");
  endtask

  task automatic setp(input int r, input int w, input int d);
    rate = W'(r); wid = W'(w); dly = W'(d);
  endtask

  initial begin
    setp(1, 3, 0);
    repeat (3) @(negedge clk);
    chk(d0, 0, "R1 reset dat"); chk(v0, 0, "R1 reset strobe");
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(v0, 0, "R1 release hold");
    sample(3);
    chk(hi0, 0, "R7 idle before trigger");

    setp(4, 2, 1); start_period(); sample(SAMPLES);
    chk(hi0, 8, "R5 rate4 highs"); chk(ri0, 4, "R5 rate4 pulses");

    setp(1, 5, 3); start_period(); sample(SAMPLES);
    chk(hi0, 5, "R4 rate1 highs"); chk(ri0, 1, "R4 rate1 pulses");

    setp(3, 2, 0); start_period(); sample(SAMPLES);
    chk(hi0, 6, "R5 rate3 highs"); chk(ri0, 3, "R5 rate3 pulses");
    hi0 = 0; sample(2 * SAMPLES);
    chk(hi0, 0, "R7 stop after period");

    setp(0, 5, 3); start_period(); sample(SAMPLES);
    chk(hi0, 5, "R5 rate0 as one");

    setp(31, 1, 0); start_period(); sample(SAMPLES);
    chk(hi0, SAMPLES, "R5 rate clamp highs"); chk(ri0, 1, "R5 rate clamp edges");

    setp(2, 0, 0); start_period(); sample(SAMPLES);
    chk(hi0, 0, "R6 zero width sync"); chk(hi1, 0, "R6 zero width live");

    setp(1, 2, 0); start_period(); sample(1);
    setp(1, 10, 0); sample(SAMPLES - 1);
    chk(hi0, 2, "R8 held settings"); chk(hi1, 10, "R9 live settings");

    setp(1, 8, 0); start_period(); sample(5);
    start_period(); sample(SAMPLES);
    chk(hi0, 8, "R7 retrigger restart");

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule